// File: doc/BRIEF.md
# Serial 10010 Pattern Detector

This block watches a one-bit serial stream, taking one bit per rising clock edge, and flags each arrival of the five-bit sequence 1, 0, 0, 1, 0, written in arrival order. The flag is Mealy-style. It is a combinational function of the stored history and the bit now on the input, so it goes high during the same cycle in which the closing 0 is presented. Consecutive occurrences may share bits. After a hit, the trailing "10" counts as the start of the next candidate.

Two implementations sit behind one parameter. The first is an encoded state machine whose five live states use plain binary codes. The second is a four-bit window of recent bits, compared against the pattern head while the live bit is compared against the tail. Both give the same flag on every cycle, so the choice is only a matter of area and timing. A synchronous active-high reset empties the history and silences the flag.

Top module: `bitseq_matcher`

## Requirements
- R1: `hit` is 1 in the cycle where `din` = 0 is presented and the four bits accepted on the previous four clock edges were 1, 0, 0, 1, oldest first.
- R2: `hit` is 0 in every cycle that does not complete the pattern, including near misses such as 1000, 10011 and 11010.
- R3: Occurrences may overlap. The stream 1,0,0,1,0,0,1,0 raises `hit` on its 5th and its 8th bit.
- R4: While `rst` is 1, `hit` is 0 whatever `din` holds. A rising edge with `rst` = 1 discards all history, so bits accepted before reset never contribute to a later hit.
- R5: `ARCH` = ARCH_FSM selects a state machine with codes 000 (nothing matched), 001 ("1"), 010 ("10"), 011 ("100") and 100 ("1001"), where codes 101 to 111 fall back to 000 with `hit` 0. `ARCH` = ARCH_WINDOW selects a four-bit shift window. Both produce identical `hit` on every cycle for any stream.
- R6: In the four cycles that follow reset release, `hit` stays 0, because the window holds fewer than four valid bits.
- R7: `hit` responds to `din` within the cycle. Once 1,0,0,1 is stored, `hit` is 0 while `din` = 1 and becomes 1 when `din` changes to 0 before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one serial bit accepted per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit |
| hit | output | 1 | Mealy detection flag for 1,0,0,1,0 |

## Verification
The hardest case to reach is the Mealy dependency inside a single cycle, where the flag must follow `din` with no edge in between. The stimulus stores 1,0,0,1, presents a 1 and samples the flag, then changes the bit to 0 in the same low clock phase and samples again. A second hard case is a reset that lands exactly when four matching bits are already held. A closing 0 presented right after release must not fire. The state-machine and window variants run side by side on a long pseudo-random stream, and both are scored against a string-free history model.

// File: rtl/bitseq_pkg.sv
`timescale 1ns/1ps
package bitseq_pkg;

    // Pattern in arrival order, first-arrived bit at the MSB.
    localparam int          PAT_LEN = 5;
    localparam logic [PAT_LEN-1:0] PATTERN = 5'b10010;
    localparam int          WIN_LEN = PAT_LEN - 1;

    typedef enum logic {
        ARCH_FSM    = 1'b0,
        ARCH_WINDOW = 1'b1
    } arch_e;

    // Binary-numbered states: how much of the pattern is matched so far.
    typedef enum logic [2:0] {
        ST_IDLE = 3'b000,
        ST_P1   = 3'b001,
        ST_P10  = 3'b010,
        ST_P100 = 3'b011,
        ST_P1001 = 3'b100
    } det_state_e;

    typedef struct packed {
        det_state_e nxt;
        logic       hit;
    } step_t;

    // One transition of the matcher; unused codes recover to idle.
    function automatic step_t fsm_step(input det_state_e cur, input logic b);
        step_t r;
        r.nxt = ST_IDLE;
        r.hit = 1'b0;
        case (cur)
            ST_IDLE:  r.nxt = b ? ST_P1   : ST_IDLE;
            ST_P1:    r.nxt = b ? ST_P1   : ST_P10;
            ST_P10:   r.nxt = b ? ST_P1   : ST_P100;
            ST_P100:  r.nxt = b ? ST_P1001 : ST_IDLE;
            ST_P1001: begin
                r.nxt = b ? ST_P1 : ST_P10;
                r.hit = ~b;
            end
            default: begin
                r.nxt = ST_IDLE;
                r.hit = 1'b0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bitseq_fsm.sv
`timescale 1ns/1ps
module bitseq_fsm
    import bitseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);

    det_state_e state_q;
    step_t      step;

    always_comb begin
        step = fsm_step(state_q, din);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= step.nxt;
        end
    end

    assign hit = step.hit & ~rst;

endmodule

// File: rtl/bitseq_window.sv
`timescale 1ns/1ps
module bitseq_window
    import bitseq_pkg::*;
#(
    parameter int WIN = WIN_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);

    localparam int CW = $clog2(WIN + 1);
    localparam logic [WIN-1:0] HEAD = PATTERN[PAT_LEN-1:1];
    localparam logic           TAIL = PATTERN[0];

    logic [WIN-1:0] win_q;   // oldest bit at MSB
    logic [CW-1:0]  fill_q;  // bits held since reset, saturating
    logic           full;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            fill_q <= '0;
        end else begin
            win_q <= {win_q[WIN-2:0], din};
            if (!full) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    assign full = (fill_q == CW'(WIN));
    assign hit  = full & ~rst & (win_q == HEAD) & (din == TAIL);

endmodule

// File: rtl/bitseq_matcher.sv
`timescale 1ns/1ps
module bitseq_matcher
    import bitseq_pkg::*;
#(
    parameter arch_e ARCH = ARCH_FSM
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);

    generate
        if (ARCH == ARCH_WINDOW) begin : g_window
            bitseq_window #(.WIN(WIN_LEN)) u_core (
                .clk (clk),
                .rst (rst),
                .din (din),
                .hit (hit)
            );
        end else begin : g_fsm
            bitseq_fsm u_core (
                .clk (clk),
                .rst (rst),
                .din (din),
                .hit (hit)
            );
        end
    endgenerate

endmodule

// File: rtl/bitseq_chk.sv
`timescale 1ns/1ps
module bitseq_chk (
    input logic clk,
    input logic rst,
    input logic din,
    input logic hit
);

    logic [2:0] since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
        end else if (since_q < 3'd4) begin
            since_q <= since_q + 3'd1;
        end
    end

    // R4: reset silences the flag
    always @(negedge clk) begin
        if (rst === 1'b1) begin
            a_r4_reset_quiet: assert (hit === 1'b0);
        end
    end

    // R1: a hit only occurs on a closing zero
    a_r1_tail_zero: assert property (@(posedge clk) disable iff (rst)
        hit |-> !din);

    // R6: no hit before four bits are held
    a_r6_fill: assert property (@(posedge clk) disable iff (rst)
        hit |-> (since_q >= 3'd4));

    // R1: the four preceding bits were 1,0,0,1
    a_r1_history: assert property (@(posedge clk) disable iff (rst)
        (hit && since_q >= 3'd4) |->
            ($past(din, 1) && !$past(din, 2) && !$past(din, 3) && $past(din, 4)));

    // R3: overlapping hits are never back to back
    a_r3_no_adjacent: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

endmodule

bind bitseq_matcher bitseq_chk u_chk (
    .clk (clk),
    .rst (rst),
    .din (din),
    .hit (hit)
);

// File: tb/sim_bitseq_matcher.sv
`timescale 1ns/1ps
module sim_bitseq_matcher;
    import bitseq_pkg::*;

    localparam time HALF = 4ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic hit0, hit1;

    int n_run  = 0;
    int n_fail = 0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t exp_q[$];

    logic [3:0] hist = '0;   // model history, newest at LSB
    int         held = 0;
    logic       done = 1'b0;

    always #HALF clk = ~clk;

    bitseq_matcher #(.ARCH(ARCH_FSM)) u0 (
        .clk (clk), .rst (rst), .din (din), .hit (hit0)
    );

    bitseq_matcher #(.ARCH(ARCH_WINDOW)) u1 (
        .clk (clk), .rst (rst), .din (din), .hit (hit1)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic model_hit(input logic b);
        return (held >= 4) && (hist == 4'b1001) && (b == 1'b0);
    endfunction

    function automatic void model_push(input logic b);
        hist = {hist[2:0], b};
        if (held < 4) held++;
    endfunction

    // Driver: one bit per cycle, expected value queued
    task automatic send(input logic b, input string tag);
        item_t it;
        @(negedge clk);
        rst = 1'b0;
        din = b;
        it.exp = model_hit(b);
        it.tag = tag;
        exp_q.push_back(it);
        model_push(b);
    endtask

    task automatic send_str(input string s, input string tag);
        for (int i = 0; i < s.len(); i++) begin
            send(s[i] == "1", tag);
        end
    endtask

    task automatic do_reset(input int cycles, input logic b);
        item_t it;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            rst = 1'b1;
            din = b;
            it.exp = 1'b0;
            it.tag = "R4";
            exp_q.push_back(it);
            hist = '0;
            held = 0;
        end
    endtask

    // R7: flag follows din inside one cycle
    task automatic mealy_toggle();
        item_t it;
        @(negedge clk);
        rst = 1'b0;
        din = 1'b1;
        #1;
        check(hit0, 1'b0, "R7");
        check(hit1, 1'b0, "R7");
        #0.5;
        din = 1'b0;
        it.exp = model_hit(1'b0);
        it.tag = "R7";
        exp_q.push_back(it);
        model_push(1'b0);
    endtask

    // Monitor: pops one expectation per cycle
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                check(hit0, it.exp, it.tag);
                check(hit1, it.exp, it.tag);
                check(hit0, hit1, "R5");
            end
        end
    end

    initial begin
        logic [15:0] lfsr;
        do_reset(3, 1'b1);
        send_str("1001", "R6");
        send(1'b0, "R1");
        send_str("010", "R3");
        send_str("1000", "R2");
        send_str("10011", "R2");
        send_str("11010", "R2");
        send_str("100100100", "R3");
        send_str("0001001", "R7");
        mealy_toggle();
        send_str("1001", "R4");
        do_reset(1, 1'b0);
        send(1'b0, "R4");
        send_str("000", "R6");
        send_str("10010", "R1");
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr[0], "R5");
        end
        send_str("0000", "R2");
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule